// File: doc/BRIEF.md
# Fault-Injectable Synchronous SRAM Model

This block is a small single-port synchronous memory whose array can be told, at run time, to misbehave in one of several distinct ways. It is paired with a memory self-test engine. A bench loads a known defect into the array, runs a test algorithm, and confirms that the algorithm flags that defect. Each defect targets one victim bit of one victim word. The write-neighbour defect also uses one aggressor word.

The memory side is a plain port: chip enable, write enable, address, write data, and registered read data. A separate configuration port selects the defect kind, the victim address and bit, the aggressor address, a polarity value, and a decay interval for the retention defect. The configuration register is loaded only while the memory is idle. Each load resets the internal access-sequence tracker and the idle counter. With the enable bit clear, the array is an ideal memory.

Top module: `fault_sram`

## Requirements
- R1: After reset every word reads 0x00, `mem_rdata` is 0 and no defect is active.
- R2: A read (`mem_ce`=1, `mem_we`=0) presents its data on `mem_rdata` one clock later, and `mem_rdata` holds its value on every other cycle. With `cfg_enable`=0, or with kind code 0, every word returns the last value written to it.
- R3: `cfg_load` takes effect only in a cycle with `mem_ce`=0 and is ignored otherwise. An accepted load resets the sequence tracker and the idle counter.
- R4: Kind code 1 (stuck cell): the victim bit is stored and read as `cfg_polarity` whatever is written. The forced stored value remains after the defect is disabled.
- R5: Kind code 2 (write neighbour): each write to the aggressor address, when it differs from the victim address, inverts the stored victim bit. The aggressor word itself is written normally.
- R6: Kind code 3 (read flip): each read of the victim word inverts the stored victim bit and returns the inverted value.
- R7: Kind code 4 (silent read flip): each read of the victim word returns the stored value unchanged and then inverts the stored victim bit. The error appears only on a later read.
- R8: Kind code 5 (transition): a write cannot change the victim bit to the value `cfg_polarity`. Changing it to the opposite value works normally.
- R9: Kind code 6 (retention): after `cfg_decay` consecutive clock edges with no write to the victim word, the stored victim bit decays to `cfg_polarity`. A write to the victim word restarts the interval.
- R10: Kind code 7 (sequence): the second of two reads of the victim word returns the victim bit inverted, when those reads directly follow two or more writes to that word. The stored content is unchanged, and any other access order gives correct data.
- R11: Kind code 8 (sense stuck): reads of the victim word return `cfg_polarity` in the victim bit while the stored content stays correct.
- R12: A defect changes only the victim bit of the victim word. Other bits and other addresses behave ideally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_ce | input | 1 | Access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | DATA_W | Write data |
| mem_rdata | output | DATA_W | Registered read data |
| cfg_load | input | 1 | Load the configuration fields (accepted only when idle) |
| cfg_enable | input | 1 | Defect active when 1 |
| cfg_kind | input | 4 | Defect kind code |
| cfg_victim_addr | input | ADDR_W | Victim word address |
| cfg_victim_bit | input | $clog2(DATA_W) | Victim bit position |
| cfg_aggr_addr | input | ADDR_W | Aggressor word address for the write-neighbour defect |
| cfg_polarity | input | 1 | Stuck, blocked, decay or forced bit value |
| cfg_decay | input | RET_W | Idle edges before the retention defect decays the bit |

## Verification
A wrong configuration register or a stray tracker state shows up on the first read of the victim word after the access pattern that should or should not trigger the defect. The error appears one cycle after that read request. Defects that corrupt stored content (read flip, silent read flip, write neighbour, retention) are checked with a second, later read, so a wrong stored bit cannot be hidden by a read-path effect. The stuck and sense-stuck kinds are separated by disabling the defect and reading the stored word back.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

   typedef enum logic [3:0] {
      FK_NONE           = 4'd0,
      FK_STUCK_CELL     = 4'd1,
      FK_WRITE_NEIGHBOR = 4'd2,
      FK_READ_FLIP      = 4'd3,
      FK_READ_SILENT    = 4'd4,
      FK_TRANSITION     = 4'd5,
      FK_RETENTION      = 4'd6,
      FK_SEQUENCE       = 4'd7,
      FK_SENSE_STUCK    = 4'd8
   } fault_kind_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WR1  = 2'd1,
      SQ_WR2  = 2'd2,
      SQ_RD1  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/fsram_cfg.sv
module fsram_cfg
   import fsram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int BIT_W  = 3,
   parameter int RET_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_ce,
   input  logic              cfg_load,
   input  logic              cfg_enable,
   input  logic [3:0]        cfg_kind,
   input  logic [ADDR_W-1:0] cfg_victim_addr,
   input  logic [BIT_W-1:0]  cfg_victim_bit,
   input  logic [ADDR_W-1:0] cfg_aggr_addr,
   input  logic              cfg_polarity,
   input  logic [RET_W-1:0]  cfg_decay,
   output fault_kind_e       act_kind,
   output logic [ADDR_W-1:0] vaddr_q,
   output logic [BIT_W-1:0]  vbit_q,
   output logic [ADDR_W-1:0] aaddr_q,
   output logic              pol_q,
   output logic [RET_W-1:0]  decay_q,
   output logic              cfg_clr
);

   logic accept;

   assign accept  = cfg_load && !mem_ce;
   assign cfg_clr = accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_kind <= FK_NONE;
         vaddr_q  <= '0;
         vbit_q   <= '0;
         aaddr_q  <= '0;
         pol_q    <= 1'b0;
         decay_q  <= '0;
      end else if (accept) begin
         act_kind <= cfg_enable ? fault_kind_e'(cfg_kind) : FK_NONE;
         vaddr_q  <= cfg_victim_addr;
         vbit_q   <= cfg_victim_bit;
         aaddr_q  <= cfg_aggr_addr;
         pol_q    <= cfg_polarity;
         decay_q  <= cfg_decay;
      end
   end

   // R3
   cfg_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load && mem_ce) |=> ($stable(act_kind) && $stable(vaddr_q) && $stable(vbit_q)
                                && $stable(pol_q) && $stable(decay_q)));

endmodule

// File: rtl/fsram_track.sv
module fsram_track
   import fsram_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int RET_W         = 8,
   parameter bit USE_RETENTION = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  fault_kind_e       kind,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [RET_W-1:0]  decay,
   input  logic              mem_ce,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic              decay_fire,
   output logic              seq_fire
);

   logic       victim_hit;
   logic       victim_wr;
   seq_state_e state;

   assign victim_hit = mem_ce && (mem_addr == vaddr);
   assign victim_wr  = victim_hit && mem_we;
   assign seq_fire   = (kind == FK_SEQUENCE) && (state == SQ_RD1) && victim_hit && !mem_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
      end else if (clr || kind != FK_SEQUENCE) begin
         state <= SQ_IDLE;
      end else if (victim_hit) begin
         if (mem_we) begin
            case (state)
               SQ_IDLE: state <= SQ_WR1;
               SQ_WR1:  state <= SQ_WR2;
               SQ_WR2:  state <= SQ_WR2;
               default: state <= SQ_WR1;
            endcase
         end else begin
            state <= (state == SQ_WR2) ? SQ_RD1 : SQ_IDLE;
         end
      end
   end

   // R10
   seq_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_fire |-> $past(victim_hit && !mem_we && kind == FK_SEQUENCE));

   generate
      if (USE_RETENTION) begin : g_ret
         logic [RET_W-1:0] idle_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idle_cnt <= '0;
            end else if (clr || victim_wr) begin
               idle_cnt <= '0;
            end else if (idle_cnt != decay) begin
               idle_cnt <= idle_cnt + 1'b1;
            end
         end

         assign decay_fire = (kind == FK_RETENTION) && (idle_cnt == decay) && !victim_wr;

         // R9
         ret_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (kind == FK_RETENTION) |-> (idle_cnt <= decay));
      end else begin : g_noret
         logic unused_ret;
         assign unused_ret = ^decay;
         assign decay_fire = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/fsram_array.sv
module fsram_array
   import fsram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int BIT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_ce,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_wdata,
   input  fault_kind_e       kind,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [BIT_W-1:0]  vbit,
   input  logic [ADDR_W-1:0] aaddr,
   input  logic              pol,
   input  logic              decay_fire,
   input  logic              seq_fire,
   output logic [DATA_W-1:0] mem_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] vmask;
   logic [DATA_W-1:0] polmask;
   logic [DATA_W-1:0] wr_val;
   logic [DATA_W-1:0] rd_val;
   logic              at_victim;
   logic              cur_bit;
   logic              wr_op;
   logic              rd_op;

   assign vmask     = DATA_W'(1) << vbit;
   assign polmask   = pol ? vmask : '0;
   assign at_victim = (mem_addr == vaddr);
   assign cur_bit   = |(mem[vaddr] & vmask);
   assign wr_op     = mem_ce && mem_we;
   assign rd_op     = mem_ce && !mem_we;

   always_comb begin
      wr_val = mem_wdata;
      if (at_victim) begin
         case (kind)
            FK_STUCK_CELL: wr_val = (mem_wdata & ~vmask) | polmask;
            FK_TRANSITION: begin
               if ((cur_bit != pol) && ((|(mem_wdata & vmask)) == pol))
                  wr_val = (mem_wdata & ~vmask) | (cur_bit ? vmask : '0);
            end
            default: wr_val = mem_wdata;
         endcase
      end
   end

   always_comb begin
      rd_val = mem[mem_addr];
      if (at_victim) begin
         case (kind)
            FK_STUCK_CELL, FK_SENSE_STUCK: rd_val = (mem[mem_addr] & ~vmask) | polmask;
            FK_READ_FLIP:                  rd_val = mem[mem_addr] ^ vmask;
            FK_SEQUENCE:                   rd_val = seq_fire ? (mem[mem_addr] ^ vmask) : mem[mem_addr];
            default:                       rd_val = mem[mem_addr];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (wr_op)
            mem[mem_addr] <= wr_val;
         if (wr_op && kind == FK_WRITE_NEIGHBOR && mem_addr == aaddr && aaddr != vaddr)
            mem[vaddr] <= mem[vaddr] ^ vmask;
         if (rd_op && at_victim && (kind == FK_READ_FLIP || kind == FK_READ_SILENT))
            mem[vaddr] <= mem[vaddr] ^ vmask;
         if (decay_fire)
            mem[vaddr] <= (mem[vaddr] & ~vmask) | polmask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_rdata <= '0;
      else if (rd_op) mem_rdata <= rd_val;
   end

   // R4
   stuck_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_op && at_victim && kind == FK_STUCK_CELL) |=> ((|(mem[vaddr] & vmask)) == pol));

   // R5
   neighbor_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_op && kind == FK_WRITE_NEIGHBOR && mem_addr == aaddr && aaddr != vaddr)
      |=> (mem[vaddr] == ($past(mem[vaddr]) ^ vmask)));

   // R8
   trans_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_op && at_victim && kind == FK_TRANSITION && cur_bit != pol)
      |=> ((|(mem[vaddr] & vmask)) != pol));

endmodule

// File: rtl/fault_sram.sv
module fault_sram
   import fsram_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int DATA_W        = 8,
   parameter int RET_W         = 8,
   parameter bit USE_RETENTION = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mem_ce,
   input  logic                      mem_we,
   input  logic [ADDR_W-1:0]         mem_addr,
   input  logic [DATA_W-1:0]         mem_wdata,
   output logic [DATA_W-1:0]         mem_rdata,
   input  logic                      cfg_load,
   input  logic                      cfg_enable,
   input  logic [3:0]                cfg_kind,
   input  logic [ADDR_W-1:0]         cfg_victim_addr,
   input  logic [$clog2(DATA_W)-1:0] cfg_victim_bit,
   input  logic [ADDR_W-1:0]         cfg_aggr_addr,
   input  logic                      cfg_polarity,
   input  logic [RET_W-1:0]          cfg_decay
);

   localparam int BIT_W = $clog2(DATA_W);

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("fault_sram: ADDR_W must be 1..10");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("fault_sram: DATA_W must be at least 2");
      end
      if (RET_W < 1) begin : g_bad_ret
         $error("fault_sram: RET_W must be at least 1");
      end
   endgenerate

   fault_kind_e       kind;
   logic [ADDR_W-1:0] vaddr;
   logic [BIT_W-1:0]  vbit;
   logic [ADDR_W-1:0] aaddr;
   logic              pol;
   logic [RET_W-1:0]  decay;
   logic              clr;
   logic              decay_fire;
   logic              seq_fire;

   fsram_cfg #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .RET_W(RET_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .mem_ce(mem_ce), .cfg_load(cfg_load),
      .cfg_enable(cfg_enable), .cfg_kind(cfg_kind), .cfg_victim_addr(cfg_victim_addr),
      .cfg_victim_bit(cfg_victim_bit), .cfg_aggr_addr(cfg_aggr_addr),
      .cfg_polarity(cfg_polarity), .cfg_decay(cfg_decay),
      .act_kind(kind), .vaddr_q(vaddr), .vbit_q(vbit), .aaddr_q(aaddr),
      .pol_q(pol), .decay_q(decay), .cfg_clr(clr)
   );

   fsram_track #(.ADDR_W(ADDR_W), .RET_W(RET_W), .USE_RETENTION(USE_RETENTION)) i_track (
      .clk(clk), .rst_n(rst_n), .clr(clr), .kind(kind), .vaddr(vaddr), .decay(decay),
      .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr),
      .decay_fire(decay_fire), .seq_fire(seq_fire)
   );

   fsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) i_array (
      .clk(clk), .rst_n(rst_n), .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .kind(kind), .vaddr(vaddr), .vbit(vbit), .aaddr(aaddr),
      .pol(pol), .decay_fire(decay_fire), .seq_fire(seq_fire), .mem_rdata(mem_rdata)
   );

   // R2
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_ce && !mem_we) |=> $stable(mem_rdata));

   // R2
   ideal_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce && mem_we && kind == FK_NONE) ##1
      (mem_ce && !mem_we && mem_addr == $past(mem_addr) && kind == FK_NONE)
      |=> (mem_rdata == $past(mem_wdata, 2)));

endmodule

// File: tb/test_fault_sram.sv
`timescale 1ns/1ps
module test_fault_sram;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mem_ce = 1'b0;
   logic       mem_we = 1'b0;
   logic [3:0] mem_addr = '0;
   logic [7:0] mem_wdata = '0;
   logic [7:0] mem_rdata;
   logic       cfg_load = 1'b0;
   logic       cfg_enable = 1'b0;
   logic [3:0] cfg_kind = '0;
   logic [3:0] cfg_victim_addr = '0;
   logic [2:0] cfg_victim_bit = '0;
   logic [3:0] cfg_aggr_addr = '0;
   logic       cfg_polarity = 1'b0;
   logic [7:0] cfg_decay = '0;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   fault_sram i_fault_sram (
      .clk(clk), .rst_n(rst_n), .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cfg_load(cfg_load),
      .cfg_enable(cfg_enable), .cfg_kind(cfg_kind), .cfg_victim_addr(cfg_victim_addr),
      .cfg_victim_bit(cfg_victim_bit), .cfg_aggr_addr(cfg_aggr_addr),
      .cfg_polarity(cfg_polarity), .cfg_decay(cfg_decay)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      mem_ce = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
      @(negedge clk);
      mem_ce = 1'b0; mem_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      mem_ce = 1'b1; mem_we = 1'b0; mem_addr = a;
      @(negedge clk);
      d = mem_rdata;
      mem_ce = 1'b0;
   endtask

   task automatic load(input logic en, input logic [3:0] k, input logic [3:0] va,
                       input logic [2:0] vb, input logic [3:0] aa, input logic p,
                       input logic [7:0] dc);
      cfg_enable = en; cfg_kind = k; cfg_victim_addr = va; cfg_victim_bit = vb;
      cfg_aggr_addr = aa; cfg_polarity = p; cfg_decay = dc; cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 rdata after reset", mem_rdata, 8'h00);
      rd(4'd0, d);  check("R1 word 0 cleared", d, 8'h00);
      rd(4'd15, d); check("R1 word 15 cleared", d, 8'h00);
   endtask

   task automatic t_ideal();
      logic [7:0] d;
      wr(4'd1, 8'h3C);
      wr(4'd2, 8'hC3);
      rd(4'd1, d); check("R2 ideal read addr1", d, 8'h3C);
      rd(4'd2, d); check("R2 ideal read addr2", d, 8'hC3);
      repeat (3) @(negedge clk);
      check("R2 rdata holds while idle", mem_rdata, 8'hC3);
      wr(4'd3, 8'h55);
      check("R2 rdata holds during write", mem_rdata, 8'hC3);
      load(1'b0, 4'd1, 4'd2, 3'd0, 4'd0, 1'b1, 8'd0);
      wr(4'd2, 8'h00);
      rd(4'd2, d); check("R2 disabled defect is ideal", d, 8'h00);
   endtask

   task automatic t_stuck();
      logic [7:0] d;
      load(1'b1, 4'd1, 4'd5, 3'd7, 4'd0, 1'b1, 8'd0);
      wr(4'd5, 8'h00);
      rd(4'd5, d); check("R4 stuck bit forced", d, 8'h80);
      wr(4'd5, 8'h7E);
      rd(4'd5, d); check("R12 other bits unaffected", d, 8'hFE);
      wr(4'd6, 8'h00);
      rd(4'd6, d); check("R12 other address unaffected", d, 8'h00);
      load(1'b0, 4'd0, 4'd0, 3'd0, 4'd0, 1'b0, 8'd0);
      rd(4'd5, d); check("R4 stored value remains forced", d, 8'hFE);
   endtask

   task automatic t_busy_load();
      logic [7:0] d;
      cfg_enable = 1'b1; cfg_kind = 4'd1; cfg_victim_addr = 4'd10; cfg_victim_bit = 3'd0;
      cfg_polarity = 1'b1; cfg_load = 1'b1;
      mem_ce = 1'b1; mem_we = 1'b0; mem_addr = 4'd0;
      @(negedge clk);
      cfg_load = 1'b0; mem_ce = 1'b0;
      wr(4'd10, 8'h00);
      rd(4'd10, d); check("R3 load ignored while busy", d, 8'h00);
   endtask

   task automatic t_neighbor();
      logic [7:0] d;
      load(1'b1, 4'd2, 4'd3, 3'd2, 4'd4, 1'b0, 8'd0);
      wr(4'd3, 8'h00);
      wr(4'd4, 8'hFF);
      rd(4'd3, d); check("R5 victim flipped by aggressor write", d, 8'h04);
      rd(4'd4, d); check("R5 aggressor written normally", d, 8'hFF);
      wr(4'd4, 8'h11);
      rd(4'd3, d); check("R5 second aggressor write flips back", d, 8'h00);
   endtask

   task automatic t_read_flip();
      logic [7:0] d;
      load(1'b1, 4'd3, 4'd7, 3'd0, 4'd0, 1'b0, 8'd0);
      wr(4'd7, 8'hA5);
      rd(4'd7, d); check("R6 first read returns flipped", d, 8'hA4);
      rd(4'd7, d); check("R6 second read flips again", d, 8'hA5);
   endtask

   task automatic t_read_silent();
      logic [7:0] d;
      load(1'b1, 4'd4, 4'd7, 3'd1, 4'd0, 1'b0, 8'd0);
      wr(4'd7, 8'hA5);
      rd(4'd7, d); check("R7 triggering read correct", d, 8'hA5);
      rd(4'd7, d); check("R7 later read shows error", d, 8'hA7);
   endtask

   task automatic t_transition();
      logic [7:0] d;
      load(1'b1, 4'd5, 4'd8, 3'd3, 4'd0, 1'b1, 8'd0);
      wr(4'd8, 8'h00);
      wr(4'd8, 8'h0F);
      rd(4'd8, d); check("R8 rising change blocked", d, 8'h07);
      load(1'b0, 4'd0, 4'd0, 3'd0, 4'd0, 1'b0, 8'd0);
      wr(4'd8, 8'hFF);
      load(1'b1, 4'd5, 4'd8, 3'd3, 4'd0, 1'b1, 8'd0);
      wr(4'd8, 8'h00);
      rd(4'd8, d); check("R8 falling change allowed", d, 8'h00);
      wr(4'd8, 8'hFF);
      rd(4'd8, d); check("R8 rising blocked again", d, 8'hF7);
   endtask

   task automatic t_retention();
      logic [7:0] d;
      load(1'b1, 4'd6, 4'd11, 3'd4, 4'd0, 1'b0, 8'd20);
      wr(4'd11, 8'hFF);
      repeat (3) @(negedge clk);
      rd(4'd11, d); check("R9 value kept before interval", d, 8'hFF);
      repeat (30) @(negedge clk);
      rd(4'd11, d); check("R9 bit decayed after interval", d, 8'hEF);
      wr(4'd11, 8'hFF);
      rd(4'd11, d); check("R9 write restarts interval", d, 8'hFF);
   endtask

   task automatic t_sequence();
      logic [7:0] d;
      load(1'b1, 4'd7, 4'd9, 3'd0, 4'd0, 1'b0, 8'd0);
      wr(4'd9, 8'h10);
      wr(4'd9, 8'h10);
      rd(4'd9, d); check("R10 first read correct", d, 8'h10);
      rd(4'd9, d); check("R10 second read inverted", d, 8'h11);
      rd(4'd9, d); check("R10 stored content unchanged", d, 8'h10);
      wr(4'd9, 8'h20);
      rd(4'd9, d);
      rd(4'd9, d); check("R10 single write gives no error", d, 8'h20);
      wr(4'd9, 8'h30);
      wr(4'd9, 8'h30);
      load(1'b1, 4'd7, 4'd9, 3'd0, 4'd0, 1'b0, 8'd0);
      rd(4'd9, d);
      rd(4'd9, d); check("R3 reload clears sequence tracker", d, 8'h30);
   endtask

   task automatic t_sense();
      logic [7:0] d;
      load(1'b1, 4'd8, 4'd12, 3'd1, 4'd0, 1'b0, 8'd0);
      wr(4'd12, 8'hFF);
      rd(4'd12, d); check("R11 read path forced", d, 8'hFD);
      load(1'b0, 4'd0, 4'd0, 3'd0, 4'd0, 1'b0, 8'd0);
      rd(4'd12, d); check("R11 stored content correct", d, 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ideal();
      t_stuck();
      t_busy_load();
      t_neighbor();
      t_read_flip();
      t_read_silent();
      t_transition();
      t_retention();
      t_sequence();
      t_sense();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule